// File: doc/BRIEF.md
# Digital Potentiometer Two-Wire Register Slave

This block is the serial control front end of a 256-step digital potentiometer. It watches an I2C-style two-wire bus (clock and data) and samples both lines through a short synchronizer on the system clock. From those samples it recognises START and STOP conditions and takes bytes MSB first. It answers only to one fixed 7-bit device identity. A write transaction carries a register address byte and then one or more data bytes. A read transaction returns the register chosen by the last address byte.

There are three registers. The volatile wiper value drives the output bus directly. The initial-value register stands in for a non-volatile cell. An access register holds a single control flag that decides what address 0 reaches. A write to address 0 with the flag set is treated as a non-volatile write. The STOP that closes such a transaction starts a programming cycle of fixed length. For that whole cycle the slave raises a busy output and ignores the bus completely.

Top module: `dpot_i2c_slave`

## Requirements
- R1: After reset, and at any time before a START condition (data falling while clock is high), the slave never pulls data low, even when a matching identity byte is clocked in.
- R2: The identity byte arrives MSB first. When its upper seven bits equal 7'b0101000, the slave pulls data low during the ninth clock, and bit 0 selects read (1) or write (0). Any other identity gets no acknowledge, and the slave stays silent until the next START.
- R3: In a write transaction the slave acknowledges the address byte and every data byte that follows it, reserved addresses included.
- R4: A write to address 0 while the access flag is clear changes only the wiper output. The initial-value register keeps its content, and every later data byte in the same transaction overwrites the wiper again.
- R5: A write to address 0 while the access flag is set updates both the wiper and the initial-value register. The STOP that closes that transaction raises busy for exactly PROG_CYCLES clocks.
- R6: While busy is high, START conditions and identity bytes are ignored: no acknowledge is given and no register changes.
- R7: A read sends one byte MSB first from the last address written. Address 0 returns the wiper when the access flag is clear and the initial-value register when it is set. Address 2 returns the access flag in bit 7 with the other bits zero. Address 1 is reserved: it reads as 0 and writes to it are discarded.
- R8: When the master acknowledges a read byte, the slave sends the same register again. When the master does not acknowledge, the slave releases data and goes idle.
- R9: A STOP that closes a read, or a write that did not touch the non-volatile location, leaves busy low.
- R10: Reset loads the initial-value register with 8'h80, copies that value to the wiper, clears the access flag and leaves busy low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the data line is pulled low (open drain) |
| wiper | output | 8 | Current wiper position |
| busy | output | 1 | High during a non-volatile programming cycle |

## Verification
The embedded assertions check properties that must hold on every clock. The slave never drives data while idle or busy. A new drive of data starts only while the sampled clock is low. The wiper changes only in the write-data phase, and the initial-value register changes only when the access flag is set. Busy rises only right after a detected STOP. The bench scenarios cover what these per-cycle properties cannot show: the full sweep of identity bytes, the exact length of the busy window, the read-back value of each register under both settings of the access flag, and the repeat-or-release choice at the master's acknowledge.

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave #(
  parameter logic [6:0] DEV_ID      = 7'b0101000,
  parameter logic [7:0] IVR_RESET   = 8'h80,
  parameter int         PROG_CYCLES = 5000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] wiper,
  output logic       busy
);

  localparam int TW = (PROG_CYCLES > 1) ? $clog2(PROG_CYCLES) : 1;
  localparam logic [7:0] A_POS = 8'd0;
  localparam logic [7:0] A_ACC = 8'd2;

  typedef enum logic [3:0] {
    S_IDLE, S_ID, S_ID_ACK, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } st_t;

  st_t st;
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;
  logic [3:0] cnt;
  logic [7:0] sh, addr, ivr;
  logic acc, rw, mack, nv_pend;
  logic [TW-1:0] tmr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_sh[SYNC_STAGES-1];
      sda_p  <= sda_sh[SYNC_STAGES-1];
    end

  wire scl_s    = scl_sh[SYNC_STAGES-1];
  wire sda_s    = sda_sh[SYNC_STAGES-1];
  wire start_dt = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_dt  = scl_s & scl_p & ~sda_p & sda_s;
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire [7:0] rx = sh;

  wire [7:0] rd_byte = (addr == A_POS) ? (acc ? ivr : wiper) :
                       (addr == A_ACC) ? {acc, 7'b0} : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      sh      <= '0;
      addr    <= '0;
      ivr     <= IVR_RESET;
      wiper   <= IVR_RESET;
      acc     <= 1'b0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      nv_pend <= 1'b0;
      sda_oe  <= 1'b0;
      busy    <= 1'b0;
      tmr     <= '0;
    end else if (busy) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      if (tmr == '0) busy <= 1'b0;
      else           tmr  <= tmr - 1'b1;
    end else if (start_dt) begin
      st     <= S_ID;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_dt) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
      if (nv_pend) begin
        busy    <= 1'b1;
        tmr     <= TW'(PROG_CYCLES - 1);
        nv_pend <= 1'b0;
      end
    end else begin
      case (st)
        S_ID, S_ADDR, S_WR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == S_ID) begin
              if (rx[7:1] == DEV_ID) begin
                rw     <= rx[0];
                sda_oe <= 1'b1;
                st     <= S_ID_ACK;
              end else begin
                st <= S_IDLE;
              end
            end else if (st == S_ADDR) begin
              addr   <= rx;
              sda_oe <= 1'b1;
              st     <= S_ADDR_ACK;
            end else begin
              if (addr == A_POS) begin
                wiper <= rx;
                if (acc) begin
                  ivr     <= rx;
                  nv_pend <= 1'b1;
                end
              end else if (addr == A_ACC) begin
                acc <= rx[7];
              end
              sda_oe <= 1'b1;
              st     <= S_WR_ACK;
            end
          end
        end
        S_ID_ACK, S_ADDR_ACK, S_WR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (st == S_ID_ACK && rw) begin
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              st     <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= (st == S_ID_ACK) ? S_ADDR : S_WR;
            end
          end
        end
        S_RD: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= S_RD_ACK;
            end else begin
              sda_oe <= ~sh[6];
              sh     <= {sh[6:0], 1'b0};
            end
          end
        end
        S_RD_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              sh     <= rd_byte;
              sda_oe <= ~rd_byte[7];
              st     <= S_RD;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe); // R1
  AST_DRIVE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R2
  AST_WIPER_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(wiper) |-> ($past(st) == S_WR)); // R4
  AST_IVR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ivr) |-> $past(acc)); // R5
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_dt)); // R5
  AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st == S_IDLE && !sda_oe)); // R6

endmodule

// File: tb/tb_dpot_i2c_slave.sv
module tb_dpot_i2c_slave;
  localparam int PROG = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic busy_clr = 1'b0;
  logic sda_oe, busy;
  logic [7:0] wiper;
  int n_run = 0, n_fail = 0, busy_cycles = 0;

  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  dpot_i2c_slave #(.PROG_CYCLES(PROG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .wiper(wiper), .busy(busy)
  );

  always @(posedge clk)
    if (busy_clr) busy_cycles <= 0;
    else if (busy) busy_cycles <= busy_cycles + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    w(3); sda_m = 1'b1; w(3); scl_m = 1'b1; w(3); sda_m = 1'b0; w(3); scl_m = 1'b0;
  endtask

  task automatic bstop();
    w(3); sda_m = 1'b0; w(3); scl_m = 1'b1; w(3); sda_m = 1'b1; w(3);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      w(3); sda_m = b[i]; w(3); scl_m = 1'b1; w(6); scl_m = 1'b0;
    end
    w(3); sda_m = 1'b1; w(3); scl_m = 1'b1; w(3); ack = ~sda_line; w(3); scl_m = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] b, input logic mack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      w(3); sda_m = 1'b1; w(3); scl_m = 1'b1; w(3); b = {b[6:0], sda_line}; w(3); scl_m = 1'b0;
    end
    w(3); sda_m = ~mack; w(3); scl_m = 1'b1; w(6); scl_m = 1'b0;
  endtask

  task automatic write_reg(input logic [7:0] a, input logic [7:0] d, output logic all_ack);
    logic k1, k2, k3;
    bstart(); wbyte(8'h50, k1); wbyte(a, k2); wbyte(d, k3); bstop();
    all_ack = k1 & k2 & k3;
  endtask

  task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
    logic k;
    bstart(); wbyte(8'h50, k); wbyte(a, k); bstart(); wbyte(8'h51, k); rbyte(d, 1'b0); bstop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ack, ok;
    logic [7:0] d, d2, exp;
    w(5); rst_n = 1'b1; w(5);
    chk(wiper == 8'h80, "R10 wiper reset", wiper, 8'h80);
    chk(busy == 1'b0, "R10 busy reset", busy, 0);
    chk(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);

    scl_m = 1'b0; w(3);
    wbyte(8'h50, ack);
    chk(ack == 1'b0, "R1 no ack without START", ack, 0);

    for (int id = 0; id < 256; id++) begin
      bstart(); wbyte(8'(id), ack); bstop();
      chk(ack == (id[7:1] == 7'h28), "R2 identity sweep", ack, id[7:1] == 7'h28);
    end

    bstart(); wbyte(8'h50, ack); wbyte(8'h00, ack);
    chk(ack, "R3 address ack", ack, 1);
    for (int v = 0; v < 256; v++) begin
      exp = 8'((v * 37 + 11) & 255);
      wbyte(exp, ack);
      chk(ack, "R3 data ack", ack, 1);
      chk(wiper == exp, "R4 wiper follows write", wiper, exp);
    end
    busy_clr = 1'b1; w(1); busy_clr = 1'b0;
    bstop(); w(20);
    chk(busy_cycles == 0, "R9 volatile write no busy", busy_cycles, 0);

    bstart(); wbyte(8'h50, ack); wbyte(8'h00, ack); bstart(); wbyte(8'h51, ack);
    rbyte(d, 1'b1); rbyte(d2, 1'b0); w(4);
    chk(d == exp, "R7 read wiper", d, exp);
    chk(d2 == exp, "R8 repeat after master ack", d2, exp);
    chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
    bstop(); w(20);
    chk(busy_cycles == 0, "R9 read no busy", busy_cycles, 0);

    write_reg(8'h02, 8'hFF, ok);
    read_reg(8'h02, d);
    chk(d == 8'h80, "R7 access reads bit7 only", d, 8'h80);
    read_reg(8'h00, d);
    chk(d == 8'h80, "R7 read initial value reset", d, 8'h80);

    busy_clr = 1'b1; w(1); busy_clr = 1'b0;
    write_reg(8'h00, 8'h3C, ok);
    chk(ok, "R3 nv write acked", ok, 1);
    chk(wiper == 8'h3C, "R5 wiper on nv write", wiper, 8'h3C);
    w(4);
    chk(busy == 1'b1, "R5 busy after stop", busy, 1);
    bstart(); wbyte(8'h50, ack); bstop();
    chk(ack == 1'b0, "R6 no ack while busy", ack, 0);
    chk(wiper == 8'h3C, "R6 wiper unchanged while busy", wiper, 8'h3C);
    while (busy) w(1);
    w(2);
    chk(busy_cycles == PROG, "R5 busy length", busy_cycles, PROG);

    read_reg(8'h00, d);
    chk(d == 8'h3C, "R5 initial value stored", d, 8'h3C);

    write_reg(8'h02, 8'h00, ok);
    busy_clr = 1'b1; w(1); busy_clr = 1'b0;
    write_reg(8'h00, 8'h99, ok);
    w(20);
    chk(busy_cycles == 0, "R9 no busy with flag clear", busy_cycles, 0);
    chk(wiper == 8'h99, "R4 volatile write", wiper, 8'h99);
    read_reg(8'h00, d);
    chk(d == 8'h99, "R7 read wiper flag clear", d, 8'h99);
    write_reg(8'h02, 8'h80, ok);
    read_reg(8'h00, d);
    chk(d == 8'h3C, "R4 initial value kept", d, 8'h3C);

    write_reg(8'h01, 8'h55, ok);
    chk(ok, "R3 reserved address acked", ok, 1);
    chk(wiper == 8'h99, "R7 reserved write discarded", wiper, 8'h99);
    read_reg(8'h01, d);
    chk(d == 8'h00, "R7 reserved reads zero", d, 0);
    read_reg(8'h02, d);
    chk(d == 8'h80, "R7 access unchanged", d, 8'h80);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule